// File: doc/BRIEF.md
# Timer Clock Routing and Gating

This block sits in front of three 16-bit timer channels and turns a set of clock candidates into one count-enable pulse per channel in the system clock domain. At block level it builds three external clock lines; each line is taken from its own input pin, from one of the other two channels' A outputs, or is held low. Each channel then picks one of eight sources: five internal clocks from a free-running prescaler and the three external lines. It may invert the chosen source so that counting happens on the opposite edge, and it may gate the result with one of the external lines.

The block also handles the per-channel start, stop and software-trigger commands. It keeps a clock-running status bit per channel, and it issues a block-wide sync that restarts all three counters in the same cycle. Asynchronous pins (the three clock pins and the slow-clock pin) pass through two-flop synchronisers before use. Every source is treated as a level and edge-detected, so each rising edge of the selected, optionally inverted, level gives exactly one count-enable cycle. The counters themselves are downstream.

Top module: `tmr_clk_route`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, `cnt_en_o`, `restart_o` and `clk_on_o` are all zero, and the prescaler starts from zero.
- R2: Each external line n has a 2-bit selector at `xc_sel_i[2n+1:2n]`. Code 0 takes synchronised pin n, code 1 holds the line low, code 2 takes the A output of the lower-numbered other channel, and code 3 takes the A output of the higher-numbered other channel. For line 0 codes 2 and 3 mean channels 1 and 2, for line 1 channels 0 and 2, and for line 2 channels 0 and 1.
- R3: Each channel's 3-bit select at `clk_sel_i[3n+2:3n]` uses codes 0 to 3 for the system clock divided by 2, 8, 32 and 128 (prescaler bits 0, 2, 4 and 6 of a counter starting at 0), code 4 for the synchronised slow-clock pin, and codes 5, 6 and 7 for external lines 0, 1 and 2.
- R4: A channel's `cnt_en_o` bit is high for exactly one cycle for each rising edge of the selected level, or each falling edge when `clk_inv_i` for that channel is 1. It rises in the cycle after the cycle in which the new level of the source is first visible.
- R5: The 2-bit gate field at `gate_sel_i[2n+1:2n]` selects no gating (0) or external line 0, 1 or 2 (codes 1 to 3). An edge that happens while the gate line is low gives no count enable.
- R6: A 1 on `en_cmd_i[n]` sets `clk_on_o[n]` and a 1 on `dis_cmd_i[n]` clears it, both seen in the next cycle. When both are 1 in the same cycle, the disable wins.
- R7: A channel whose clock is off produces no count enable.
- R8: A 1 on `trg_cmd_i[n]` gives a one-cycle `restart_o[n]` pulse in the next cycle, whether or not the clock is on.
- R9: A 1 on `sync_cmd_i` gives `restart_o` pulses on all three channels in the same next cycle.
- R10: A clock pin change driven before clock edge k reaches a channel selecting it through external line 0/1/2 as a count enable that is visible after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tclk_pin_i | input | 3 | Asynchronous clock pins, one per external line |
| slow_pin_i | input | 1 | Asynchronous slow clock used as internal clock code 4 |
| ch_a_i | input | 3 | A outputs of the three channels (synchronous) |
| xc_sel_i | input | 6 | Source selector of each external line, 2 bits per line |
| clk_sel_i | input | 9 | Clock source select per channel, 3 bits each |
| clk_inv_i | input | 3 | Count on the falling edge of the selected source, per channel |
| gate_sel_i | input | 6 | Gate selector per channel, 2 bits each |
| en_cmd_i | input | 3 | Write-one clock start command per channel |
| dis_cmd_i | input | 3 | Write-one clock stop command per channel |
| trg_cmd_i | input | 3 | Write-one software trigger per channel |
| sync_cmd_i | input | 1 | Block-wide trigger for all channels |
| cnt_en_o | output | 3 | One-cycle count enable per channel |
| restart_o | output | 3 | One-cycle counter restart per channel |
| clk_on_o | output | 3 | Clock-running status per channel |

## Verification
The bench goes after a start and stop written in the same cycle: a design that gives the enable priority would leave the clock running and keep counting. It drives inverted sources and checks that pulses move to the falling edge; an edge detector that ignores inversion would count one half-period early. It gates with a line that is low, where a missing gate would let pulses through. It checks the pin-to-enable latency and the cross-channel codes of each external line, where a wrong index or a missing synchroniser stage would shift or misroute every pulse.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int NCH     = 3;
  localparam int XSEL_W  = 2;
  localparam int CSEL_W  = 3;
  localparam int GSEL_W  = 2;
  localparam int NUM_DIV = 4;
  localparam int NUM_INT = NUM_DIV + 1;
  localparam int PRE_W   = 2 * (NUM_DIV - 1) + 1;
  localparam int NSRC    = NUM_INT + NCH;

  typedef enum logic [XSEL_W-1:0] {
    XS_PIN  = 2'd0,
    XS_NONE = 2'd1,
    XS_LO   = 2'd2,
    XS_HI   = 2'd3
  } xsrc_e;
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/tcr_prescale.sv
module tcr_prescale
  import tcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_lvl_i,
  output logic [NUM_INT-1:0] int_lvl_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    assign int_lvl_o[k] = cnt_q[2*k];
  end
  assign int_lvl_o[NUM_INT-1] = slow_lvl_i;
endmodule

// File: rtl/tcr_xc_mux.sv
module tcr_xc_mux
  import tcr_pkg::*;
(
  input  logic [NCH-1:0]        pin_lvl_i,
  input  logic [NCH-1:0]        ch_a_i,
  input  logic [NCH*XSEL_W-1:0] xc_sel_i,
  output logic [NCH-1:0]        xc_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_line
    localparam int LO = (n == 0) ? 1 : 0;
    localparam int HI = (n == NCH-1) ? NCH-2 : NCH-1;
    xsrc_e code;
    assign code = xsrc_e'(xc_sel_i[n*XSEL_W +: XSEL_W]);
    always_comb begin
      case (code)
        XS_PIN:  xc_o[n] = pin_lvl_i[n];
        XS_LO:   xc_o[n] = ch_a_i[LO];
        XS_HI:   xc_o[n] = ch_a_i[HI];
        default: xc_o[n] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tcr_chan_clk.sv
module tcr_chan_clk
  import tcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_lvl_i,
  input  logic [NCH-1:0]     xc_i,
  input  logic [CSEL_W-1:0]  clk_sel_i,
  input  logic               clk_inv_i,
  input  logic [GSEL_W-1:0]  gate_sel_i,
  input  logic               en_cmd_i,
  input  logic               dis_cmd_i,
  input  logic               trg_cmd_i,
  input  logic               sync_cmd_i,
  output logic               cnt_en_o,
  output logic               restart_o,
  output logic               clk_on_o
);
  logic [NSRC-1:0] src_vec;
  logic [NCH:0]    gate_vec;
  logic            lvl;
  logic            prev_q;
  logic            edge_hit;
  logic            gate_ok;
  logic            on_q, on_d;
  logic            cen_q, cen_d;
  logic            rst_q, rst_d;

  assign src_vec  = {xc_i, int_lvl_i};
  assign gate_vec = {xc_i, 1'b1};

  always_comb begin
    lvl      = src_vec[clk_sel_i] ^ clk_inv_i;
    edge_hit = lvl & ~prev_q;
    gate_ok  = gate_vec[gate_sel_i];
    cen_d    = on_q & edge_hit & gate_ok;
    if (dis_cmd_i)     on_d = 1'b0;
    else if (en_cmd_i) on_d = 1'b1;
    else               on_d = on_q;
    rst_d    = trg_cmd_i | sync_cmd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      on_q   <= 1'b0;
      cen_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      on_q   <= on_d;
      cen_q  <= cen_d;
      rst_q  <= rst_d;
    end
  end

  assign cnt_en_o  = cen_q;
  assign restart_o = rst_q;
  assign clk_on_o  = on_q;

  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd_i |=> !clk_on_o); // R6
  AST_EN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd_i && !dis_cmd_i) |=> clk_on_o); // R6
  AST_OFF_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on_o |=> !cnt_en_o); // R7
  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_vec[gate_sel_i] |=> !cnt_en_o); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_o |=> !cnt_en_o); // R4
  AST_TRG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    trg_cmd_i |=> restart_o); // R8
endmodule

// File: rtl/tmr_clk_route.sv
module tmr_clk_route
  import tcr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        tclk_pin_i,
  input  logic                  slow_pin_i,
  input  logic [NCH-1:0]        ch_a_i,
  input  logic [NCH*XSEL_W-1:0] xc_sel_i,
  input  logic [NCH*CSEL_W-1:0] clk_sel_i,
  input  logic [NCH-1:0]        clk_inv_i,
  input  logic [NCH*GSEL_W-1:0] gate_sel_i,
  input  logic [NCH-1:0]        en_cmd_i,
  input  logic [NCH-1:0]        dis_cmd_i,
  input  logic [NCH-1:0]        trg_cmd_i,
  input  logic                  sync_cmd_i,
  output logic [NCH-1:0]        cnt_en_o,
  output logic [NCH-1:0]        restart_o,
  output logic [NCH-1:0]        clk_on_o
);
  logic               rs1_q, rs2_q;
  logic               rst_int_n;
  logic [NCH:0]       pin_sync;
  logic [NUM_INT-1:0] int_lvl;
  logic [NCH-1:0]     xc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  tcr_sync #(.W(NCH+1)) i_pin_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({slow_pin_i, tclk_pin_i}),
    .q_o   (pin_sync)
  );

  tcr_prescale i_prescale (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .slow_lvl_i (pin_sync[NCH]),
    .int_lvl_o  (int_lvl)
  );

  tcr_xc_mux i_xc_mux (
    .pin_lvl_i (pin_sync[NCH-1:0]),
    .ch_a_i    (ch_a_i),
    .xc_sel_i  (xc_sel_i),
    .xc_o      (xc)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    tcr_chan_clk i_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .int_lvl_i  (int_lvl),
      .xc_i       (xc),
      .clk_sel_i  (clk_sel_i[n*CSEL_W +: CSEL_W]),
      .clk_inv_i  (clk_inv_i[n]),
      .gate_sel_i (gate_sel_i[n*GSEL_W +: GSEL_W]),
      .en_cmd_i   (en_cmd_i[n]),
      .dis_cmd_i  (dis_cmd_i[n]),
      .trg_cmd_i  (trg_cmd_i[n]),
      .sync_cmd_i (sync_cmd_i),
      .cnt_en_o   (cnt_en_o[n]),
      .restart_o  (restart_o[n]),
      .clk_on_o   (clk_on_o[n])
    );
  end

  AST_SYNC_ALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_cmd_i |=> (&restart_o)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (cnt_en_o == '0 && restart_o == '0 && clk_on_o == '0)); // R1
endmodule

// File: tb/test_tmr_clk_route.sv
module test_tmr_clk_route;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] tclk_pin, ch_a, clk_inv, en_cmd, dis_cmd, trg_cmd;
  logic       slow_pin, sync_cmd;
  logic [5:0] xc_sel, gate_sel;
  logic [8:0] clk_sel;
  logic [2:0] cnt_en, restart, clk_on;

  int vec_cnt = 0;
  int err_cnt = 0;

  // bench-side expectation state
  logic [2:0] m_p1, m_p2, m_prev, m_on, m_cen, m_rst;
  logic       m_s1, m_s2;
  logic [6:0] m_pre;

  always #4 clk = ~clk;

  tmr_clk_route i_tmr_clk_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .tclk_pin_i (tclk_pin),
    .slow_pin_i (slow_pin),
    .ch_a_i     (ch_a),
    .xc_sel_i   (xc_sel),
    .clk_sel_i  (clk_sel),
    .clk_inv_i  (clk_inv),
    .gate_sel_i (gate_sel),
    .en_cmd_i   (en_cmd),
    .dis_cmd_i  (dis_cmd),
    .trg_cmd_i  (trg_cmd),
    .sync_cmd_i (sync_cmd),
    .cnt_en_o   (cnt_en),
    .restart_o  (restart),
    .clk_on_o   (clk_on)
  );

  function automatic logic xc_line(input int n);
    case (xc_sel[2*n +: 2])
      2'd0:    return m_p2[n];
      2'd1:    return 1'b0;
      2'd2:    return ch_a[(n == 0) ? 1 : 0];
      default: return ch_a[(n == 2) ? 1 : 2];
    endcase
  endfunction

  task automatic model_next();
    logic [2:0] xc, nc, np, no, nr;
    logic [7:0] src;
    logic [3:0] gv;
    logic       lv;
    for (int n = 0; n < 3; n++) xc[n] = xc_line(n);
    src = {xc, m_s2, m_pre[6], m_pre[4], m_pre[2], m_pre[0]};
    gv  = {xc, 1'b1};
    for (int n = 0; n < 3; n++) begin
      lv    = src[clk_sel[3*n +: 3]] ^ clk_inv[n];
      nc[n] = m_on[n] & lv & ~m_prev[n] & gv[gate_sel[2*n +: 2]];
      np[n] = lv;
      no[n] = dis_cmd[n] ? 1'b0 : (en_cmd[n] ? 1'b1 : m_on[n]);
      nr[n] = trg_cmd[n] | sync_cmd;
    end
    m_cen = nc; m_prev = np; m_on = no; m_rst = nr;
    m_pre = m_pre + 7'd1;
    m_p2 = m_p1; m_p1 = tclk_pin;
    m_s2 = m_s1; m_s1 = slow_pin;
  endtask

  task automatic compare(input string tag);
    vec_cnt++;
    if (cnt_en !== m_cen || restart !== m_rst || clk_on !== m_on) begin
      err_cnt++;
      $display("FAIL %s t=%0t cnt_en=%b/%b restart=%b/%b clk_on=%b/%b (actual/expected)",
               tag, $time, cnt_en, m_cen, restart, m_rst, clk_on, m_on);
    end
  endtask

  task automatic step(input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      model_next();
      @(negedge clk);
      compare(tag);
      en_cmd = '0; dis_cmd = '0; trg_cmd = '0; sync_cmd = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    err_cnt++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    tclk_pin = '0; slow_pin = 1'b0; ch_a = '0; xc_sel = 6'b010101;
    clk_sel = '0; clk_inv = '0; gate_sel = '0;
    en_cmd = '0; dis_cmd = '0; trg_cmd = '0; sync_cmd = 1'b0;
    m_p1 = '0; m_p2 = '0; m_prev = '1; m_on = '0; m_cen = '0; m_rst = '0;
    m_s1 = 1'b0; m_s2 = 1'b0; m_pre = '0;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    compare("R1 after release");

    // R3/R6: start channel 0 on divide-by-2
    en_cmd = 3'b001;
    step("R6 enable", 1);
    step("R3 div2", 8);
    // R6: start and stop together, stop wins
    en_cmd = 3'b001; dis_cmd = 3'b001;
    step("R6 disable wins", 1);
    // R7: off channel stays silent
    step("R7 clock off", 6);
    // R3 div8 on channel 1, slow pin on channel 2
    clk_sel = {3'd4, 3'd1, 3'd0};
    en_cmd = 3'b110;
    step("R3 div8 and slow", 4);
    slow_pin = 1'b1;
    step("R3 slow pin", 5);
    // R10/R2: pin 0 through line 0 on channel 0
    en_cmd = 3'b111; clk_sel = {3'd4, 3'd1, 3'd5}; xc_sel = 6'b010100;
    step("R2 pin select", 2);
    tclk_pin[0] = 1'b1;
    step("R10 pin latency", 4);
    // R4 inversion on falling edge
    clk_inv[0] = 1'b1;
    step("R4 invert", 2);
    tclk_pin[0] = 1'b0;
    step("R4 invert falling", 4);
    clk_inv[0] = 1'b0;
    // R2: line 0 from channel 1 A, line 1 from channel 2 A, line 2 from channel 1 A
    xc_sel = {2'd3, 2'd3, 2'd2}; clk_sel = {3'd7, 3'd6, 3'd5};
    step("R2 cross select", 2);
    ch_a = 3'b110;
    step("R2 A outputs", 3);
    ch_a = 3'b000;
    step("R2 A outputs low", 2);
    // R5: gate channel 0 by line 1 (low), then high
    clk_sel = {3'd7, 3'd6, 3'd0}; gate_sel = {2'd0, 2'd0, 2'd2}; xc_sel = 6'b010101;
    step("R5 gate low", 6);
    xc_sel = 6'b011101; ch_a[2] = 1'b1;
    step("R5 gate high", 6);
    gate_sel = '0;
    // R8/R9 triggers
    trg_cmd = 3'b010;
    step("R8 trigger", 2);
    sync_cmd = 1'b1;
    step("R9 sync", 2);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 15) == 0) tclk_pin = 3'($urandom);
      if ($urandom_range(0, 31) == 0) slow_pin = ~slow_pin;
      if ($urandom_range(0, 7) == 0)  ch_a = 3'($urandom);
      if ($urandom_range(0, 99) == 0) begin
        xc_sel = 6'($urandom); clk_sel = 9'($urandom);
        clk_inv = 3'($urandom); gate_sel = 6'($urandom);
      end
      if ($urandom_range(0, 7) == 0)  en_cmd = 3'($urandom);
      if ($urandom_range(0, 31) == 0) dis_cmd = 3'($urandom);
      if ($urandom_range(0, 15) == 0) trg_cmd = 3'($urandom);
      if ($urandom_range(0, 63) == 0) sync_cmd = 1'b1;
      step("R4 random mix", 1);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule